// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block is a synchronous master for a 16-bit static RAM that has no clock. A requester hands it one word per transaction over a valid/ready channel. Each request carries a 20-bit word address, a write flag, a two-bit lane mask and write data. The controller turns that request into a timed sequence of chip select, write enable, output enable and per-byte lane selects. It also decides when it may drive the shared data bus. On a read it captures the returned word. When the transaction is over it gives a single-cycle completion pulse, and on a read the captured data travels with that pulse.

The length of each phase is counted in clock cycles. Each count comes from a nanosecond minimum divided by the clock period and rounded up, with one cycle as the floor. With a 4 ns clock these are the counts:

| Interval | Nanosecond sources | Cycles |
|---|---|---|
| Read strobe window | 70 ns address access, 35 ns output-enable access, 70 ns cycle time | 18 |
| Write-enable pulse | 50 ns pulse, 60 ns address before end of write, 30 ns data setup | 15 |
| Write tail | fills out the 70 ns cycle time | 3 |
| Bus float after a read | 25 ns release to high impedance | 7 |

Changing the clock-period parameter recomputes every count.

Top module: `sramCtl`

## Requirements
- R1: While reset is held, the controller keeps these outputs idle: sramCs1N, sramWeN and sramOeN high, sramDqOe low, both sramLaneN bits high, rspDone low and reqReady high.
- R2: A read returns on rspRdata the word stored at the requested address. sramAddr equals the full 20-bit request address while chip select is active.
- R3: During a read, chip select and output enable stay low together for at least ceil(max(70, 35) ns / period) cycles (18 at 4 ns) before the data is captured.
- R4: During a write, sramWeN stays low for at least ceil(max(50, 60, 30) ns / period) cycles (15 at 4 ns). sramAddr, sramLaneN and sramDqOut do not change while it is low. The driven word is stored when sramWeN rises.
- R5: Two successive falling edges of sramCs1N are at least ceil(70 ns / period) cycles apart (18 at 4 ns).
- R6: After sramOeN rises, sramDqOe stays low for at least ceil(25 ns / period) cycles (7 at 4 ns). sramDqOe is never high while sramOeN is low.
- R7: Mask bit 0 enables sramLaneN[0], which covers data bits 7:0. Mask bit 1 enables sramLaneN[1], which covers bits 15:8. Both lane selects are active low. On a write, a lane whose mask bit is 0 keeps its stored byte. On a read, that lane returns 8'h00.
- R8: Whenever reqReady is high, sramCs1N, sramWeN and sramOeN are high and sramDqOe is low. sramCs2 is high at all times.
- R9: reqReady drops in the cycle after a request is accepted and stays low until completion. Each request produces exactly one rspDone pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqAddr | input | 20 | Word address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMask | input | 2 | Lane enables, bit 0 = low byte, bit 1 = high byte |
| reqWdata | input | 16 | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read data, valid with rspDone after a read |
| sramAddr | output | 20 | Address to the memory |
| sramCs1N | output | 1 | Active-low chip select |
| sramCs2 | output | 1 | Active-high chip select, held high |
| sramWeN | output | 1 | Active-low write enable |
| sramOeN | output | 1 | Active-low output enable |
| sramLaneN | output | 2 | Active-low byte lane selects |
| sramDqOut | output | 16 | Data driven toward the memory |
| sramDqOe | output | 1 | Data bus drive enable |
| sramDqIn | input | 16 | Data returned by the memory |

## Verification
The test runs directed transactions first. These are full-word writes and reads, each single-lane mask, the empty mask in both directions, the top address, and a write issued right after a read. The single-lane and empty-mask cases show whether lane selects are mapped and masked correctly. The read-then-write case exposes a drive turnaround that is too short. After that come seeded random mixes of address, direction, mask and data, measured by a memory model that times every strobe edge. This shows whether any phase count falls below its nanosecond minimum and whether stored data drifts from the bench's own expected image.

// File: rtl/sramCtlPkg.sv
package sramCtlPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_READ_FLOAT,
    ST_WRITE,
    ST_WRITE_TAIL
  } ctlStateT;

  // Strobes from the sequencer to the datapath, all active high.
  typedef struct packed {
    logic chipSel;
    logic writeEn;
    logic outEn;
    logic busDrive;
    logic loadReq;
    logic captureRd;
  } strobeT;

  // Whole clock cycles covering a nanosecond minimum, never below one.
  function automatic int cyclesFor(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramCtlFsm.sv
module sramCtlFsm
  import sramCtlPkg::*;
#(
  parameter int NUM_READ  = 18,
  parameter int NUM_FLOAT = 7,
  parameter int NUM_WRITE = 15,
  parameter int NUM_TAIL  = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output logic   rspDone,
  output strobeT strobes
);

  localparam int MAX_CNT = maxOf(maxOf(NUM_READ, NUM_FLOAT), maxOf(NUM_WRITE, NUM_TAIL));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  ctlStateT stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic doneQ, doneD;
  logic lastCycle;

  assign lastCycle = (cntQ == '0);

  always_comb begin
    stateD  = stateQ;
    cntD    = cntQ;
    doneD   = 1'b0;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobes.loadReq = 1'b1;
          stateD = reqWrite ? ST_WRITE : ST_READ;
          cntD   = reqWrite ? CNT_W'(NUM_WRITE - 1) : CNT_W'(NUM_READ - 1);
        end
      end
      ST_READ: begin
        strobes.chipSel = 1'b1;
        strobes.outEn   = 1'b1;
        if (lastCycle) begin
          strobes.captureRd = 1'b1;
          doneD  = 1'b1;
          stateD = ST_READ_FLOAT;
          cntD   = CNT_W'(NUM_FLOAT - 1);
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_READ_FLOAT: begin
        if (lastCycle) stateD = ST_IDLE;
        else           cntD = cntQ - 1'b1;
      end
      ST_WRITE: begin
        strobes.chipSel  = 1'b1;
        strobes.writeEn  = 1'b1;
        strobes.busDrive = 1'b1;
        if (lastCycle) begin
          stateD = ST_WRITE_TAIL;
          cntD   = CNT_W'(NUM_TAIL - 1);
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_WRITE_TAIL: begin
        if (lastCycle) begin
          doneD  = 1'b1;
          stateD = ST_IDLE;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      doneQ  <= doneD;
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign rspDone  = doneQ;

  // Run-length counters that feed the timing assertions only.
  logic [CNT_W:0] weRun, oeRun, floatRun;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      weRun    <= '0;
      oeRun    <= '0;
      floatRun <= '1;
    end else begin
      weRun <= strobes.writeEn ? weRun + 1'b1 : '0;
      oeRun <= strobes.outEn   ? oeRun + 1'b1 : '0;
      if (strobes.outEn)      floatRun <= '0;
      else if (~&floatRun)    floatRun <= floatRun + 1'b1;
    end
  end

  // R4: the write pulse lasts the full computed count
  p_we_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.writeEn) |-> (int'(weRun) >= NUM_WRITE));

  // R3: the read window lasts the full computed count
  p_read_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.outEn) |-> (int'(oeRun) >= NUM_READ));

  // R6: drive waits for the memory outputs to float
  p_float_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.busDrive) |-> (int'(floatRun) >= NUM_FLOAT));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R8: an idle controller has every strobe released
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !(strobes.chipSel || strobes.writeEn || strobes.outEn || strobes.busDrive));

endmodule

// File: rtl/sramCtlData.sv
module sramCtlData
  import sramCtlPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 strobes,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W/8-1:0]    reqMask,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic [DATA_W-1:0]      rspRdata,
  output logic [ADDR_W-1:0]      sramAddr,
  output logic                   sramCs1N,
  output logic                   sramWeN,
  output logic                   sramOeN,
  output logic [DATA_W/8-1:0]    sramLaneN,
  output logic [DATA_W-1:0]      sramDqOut,
  output logic                   sramDqOe,
  input  logic [DATA_W-1:0]      sramDqIn
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] wdataQ, rdataQ, rdMasked;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sramLaneN[i]       = ~(strobes.chipSel & maskQ[i]);
    assign rdMasked[i*8 +: 8] = maskQ[i] ? sramDqIn[i*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      maskQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strobes.loadReq) begin
        addrQ  <= reqAddr;
        maskQ  <= reqMask;
        wdataQ <= reqWdata;
      end
      if (strobes.captureRd) rdataQ <= rdMasked;
    end
  end

  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = strobes.busDrive;
  assign sramCs1N  = ~strobes.chipSel;
  assign sramWeN   = ~strobes.writeEn;
  assign sramOeN   = ~strobes.outEn;
  assign rspRdata  = rdataQ;

  // R4: address, lanes and data hold still while the write pulse is low
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeEn && $past(strobes.writeEn)) |->
      ($stable(sramAddr) && $stable(sramLaneN) && $stable(sramDqOut)));

  // R6: never drive the bus while the memory may drive it
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> sramOeN);

endmodule

// File: rtl/sramCtl.sv
module sramCtl
  import sramCtlPkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int DATA_W          = 16,
  parameter int CLK_PERIOD_NS   = 4,
  parameter int T_CYCLE_NS      = 70,
  parameter int T_ADDR_ACC_NS   = 70,
  parameter int T_OE_ACC_NS     = 35,
  parameter int T_WE_PULSE_NS   = 50,
  parameter int T_ADDR_WE_NS    = 60,
  parameter int T_DATA_SETUP_NS = 30,
  parameter int T_BUS_FLOAT_NS  = 25
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic [DATA_W/8-1:0] reqMask,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspDone,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   sramAddr,
  output logic                sramCs1N,
  output logic                sramCs2,
  output logic                sramWeN,
  output logic                sramOeN,
  output logic [DATA_W/8-1:0] sramLaneN,
  output logic [DATA_W-1:0]   sramDqOut,
  output logic                sramDqOe,
  input  logic [DATA_W-1:0]   sramDqIn
);

  localparam int NUM_CYCLE = cyclesFor(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int NUM_READ  = maxOf(NUM_CYCLE,
                               maxOf(cyclesFor(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                     cyclesFor(T_OE_ACC_NS, CLK_PERIOD_NS)));
  localparam int NUM_WRITE = maxOf(cyclesFor(T_WE_PULSE_NS, CLK_PERIOD_NS),
                               maxOf(cyclesFor(T_ADDR_WE_NS, CLK_PERIOD_NS),
                                     cyclesFor(T_DATA_SETUP_NS, CLK_PERIOD_NS)));
  localparam int NUM_TAIL  = maxOf(1, NUM_CYCLE - NUM_WRITE);
  localparam int NUM_FLOAT = cyclesFor(T_BUS_FLOAT_NS, CLK_PERIOD_NS);

  strobeT strobes;

  sramCtlFsm #(
    .NUM_READ (NUM_READ),
    .NUM_FLOAT(NUM_FLOAT),
    .NUM_WRITE(NUM_WRITE),
    .NUM_TAIL (NUM_TAIL)
  ) i_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .rspDone (rspDone),
    .strobes (strobes)
  );

  sramCtlData #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqMask  (reqMask),
    .reqWdata (reqWdata),
    .rspRdata (rspRdata),
    .sramAddr (sramAddr),
    .sramCs1N (sramCs1N),
    .sramWeN  (sramWeN),
    .sramOeN  (sramOeN),
    .sramLaneN(sramLaneN),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe),
    .sramDqIn (sramDqIn)
  );

  assign sramCs2 = 1'b1;

endmodule

// File: tb/test_sramCtl.sv
`timescale 1ns/1ps
module test_sramCtl;

  localparam int PER = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [19:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqMask = '0;
  logic [15:0] reqWdata = '0;
  logic        rspDone;
  logic [15:0] rspRdata;
  logic [19:0] sramAddr;
  logic        sramCs1N, sramCs2, sramWeN, sramOeN, sramDqOe;
  logic [1:0]  sramLaneN;
  logic [15:0] sramDqOut, sramDqIn;

  always #2 clk = ~clk;

  sramCtl i_sramCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqMask(reqMask), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata), .sramAddr(sramAddr),
    .sramCs1N(sramCs1N), .sramCs2(sramCs2), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .sramLaneN(sramLaneN), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe),
    .sramDqIn(sramDqIn)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int ceilDiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction

  function automatic logic [15:0] expRead(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  function automatic logic [15:0] expWrite(input logic [15:0] old, input logic [15:0] nw,
                                           input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  // Memory model (device) and expected image (bench), 64 words by low address bits.
  logic [15:0] mem  [64];
  logic [15:0] refm [64];
  logic [5:0]  ma;
  assign ma = sramAddr[5:0];
  assign sramDqIn = (!sramCs1N && sramCs2 && !sramOeN) ?
                    {sramLaneN[1] ? 8'hA5 : mem[ma][15:8], sramLaneN[0] ? 8'h5A : mem[ma][7:0]} :
                    16'hC3C3;

  // Strobe monitor, sampled at the falling edge.
  int cyc = 0;
  int weLow = 0, dqRun = 0, oeLow = 0, lastOeLow = 0;
  int oeRise = 0, csFall = 0;
  bit oeSeen = 0, csSeen = 0, addrMoved = 0;
  int contention = 0, idleBad = 0;
  logic [19:0] prevAddr = '0, addrAtCs = '0;
  logic [1:0]  prevLane = 2'b11;
  logic [15:0] prevDq = '0;
  logic        prevWeN = 1'b1, prevOeN = 1'b1, prevCsN = 1'b1, prevDqOe = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (!sramWeN) begin
        if (prevWeN) begin
          weLow = 1; dqRun = 1; addrMoved = 0;
        end else begin
          weLow++;
          if (sramAddr != prevAddr || sramLaneN != prevLane) addrMoved = 1;
          if (sramDqOut == prevDq && sramDqOe && prevDqOe) dqRun++;
          else dqRun = 1;
        end
      end else if (!prevWeN) begin
        chk(weLow * PER >= 50, "R4", "write pulse ns", weLow * PER, 50);
        chk(weLow * PER >= 60, "R4", "address before end of write ns", weLow * PER, 60);
        chk(dqRun * PER >= 30, "R4", "data setup ns", dqRun * PER, 30);
        chk(!addrMoved, "R4", "address or lanes moved during pulse", addrMoved, 0);
        if (!prevLane[0]) mem[prevAddr[5:0]][7:0]  = prevDq[7:0];
        if (!prevLane[1]) mem[prevAddr[5:0]][15:8] = prevDq[15:8];
      end
      if (!sramOeN) oeLow = prevOeN ? 1 : oeLow + 1;
      else if (!prevOeN) begin
        lastOeLow = oeLow; oeRise = cyc; oeSeen = 1;
      end
      if (sramDqOe && !prevDqOe && oeSeen)
        chk((cyc - oeRise) * PER >= 25, "R6", "bus float gap ns", (cyc - oeRise) * PER, 25);
      if (sramDqOe && !sramOeN) contention++;
      if (!sramCs1N && prevCsN) begin
        if (csSeen)
          chk((cyc - csFall) * PER >= 70, "R5", "select spacing ns", (cyc - csFall) * PER, 70);
        csFall = cyc; csSeen = 1; addrAtCs = sramAddr;
      end
      if (reqReady && !(sramCs1N && sramWeN && sramOeN && !sramDqOe)) idleBad++;
      if (!sramCs2) idleBad++;
      prevWeN = sramWeN; prevOeN = sramOeN; prevCsN = sramCs1N; prevDqOe = sramDqOe;
      prevAddr = sramAddr; prevLane = sramLaneN; prevDq = sramDqOut;
    end
  end

  task automatic doOp(input logic [19:0] a, input bit wr, input logic [1:0] m,
                      input logic [15:0] d);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqMask = m; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R9", "ready low while busy", reqReady, 0);
    n = 0;
    while (!rspDone && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(rspDone == 1'b1, "R9", "completion pulse seen", rspDone, 1);
    #1;
    chk(addrAtCs == a, "R2", "address on pins", addrAtCs, a);
    if (!wr) begin
      chk(rspRdata == expRead(refm[a[5:0]], m), (m == 2'b11) ? "R2" : "R7",
          "read data", rspRdata, expRead(refm[a[5:0]], m));
      chk(lastOeLow >= ceilDiv(70), "R3", "read window cycles", lastOeLow, ceilDiv(70));
      chk(lastOeLow * PER >= 35, "R3", "output enable access ns", lastOeLow * PER, 35);
    end else begin
      refm[a[5:0]] = expWrite(refm[a[5:0]], d, m);
      chk(mem[a[5:0]] == refm[a[5:0]], (m == 2'b11) ? "R4" : "R7",
          "stored word", mem[a[5:0]], refm[a[5:0]]);
    end
    @(negedge clk);
    chk(rspDone == 1'b0, "R9", "completion one cycle wide", rspDone, 0);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]  = 16'(i * 16'h0101) ^ 16'h5A3C;
      refm[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
    end
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1: idle outputs during reset
    chk(sramCs1N && sramWeN && sramOeN && !sramDqOe, "R1", "strobes idle in reset",
        {sramCs1N, sramWeN, sramOeN, sramDqOe}, 4'b1110);
    chk(sramLaneN == 2'b11, "R1", "lanes idle in reset", sramLaneN, 2'b11);
    chk(!rspDone && reqReady, "R1", "handshake idle in reset", {rspDone, reqReady}, 2'b01);
    rstN = 1'b1;

    // Directed corners
    doOp(20'h00003, 1'b1, 2'b11, 16'hBEEF);
    doOp(20'h00003, 1'b0, 2'b11, 16'h0000);
    doOp(20'h00003, 1'b1, 2'b01, 16'h1234);  // R7 lower lane only
    doOp(20'h00003, 1'b0, 2'b11, 16'h0000);
    doOp(20'h00003, 1'b1, 2'b10, 16'hCA00);  // R7 upper lane only
    doOp(20'h00003, 1'b0, 2'b01, 16'h0000);
    doOp(20'h00003, 1'b0, 2'b10, 16'h0000);
    doOp(20'h00003, 1'b1, 2'b00, 16'hFFFF);  // R7 empty mask writes nothing
    doOp(20'h00003, 1'b0, 2'b11, 16'h0000);
    doOp(20'h00003, 1'b0, 2'b00, 16'h0000);  // R7 empty mask reads zero
    doOp(20'hFFFFF, 1'b1, 2'b11, 16'h55AA);  // R2 top address
    doOp(20'hFFFFF, 1'b0, 2'b11, 16'h0000);
    doOp(20'h00010, 1'b0, 2'b11, 16'h0000);  // R6 read then write
    doOp(20'h00010, 1'b1, 2'b11, 16'h0F0F);

    // Seeded random mix
    for (int k = 0; k < 80; k++) begin
      doOp(20'($urandom), 1'($urandom), 2'($urandom), 16'($urandom));
    end

    @(negedge clk);
    chk(contention == 0, "R6", "cycles driving with output enabled", contention, 0);
    chk(idleBad == 0, "R8", "idle cycles with strobes active", idleBad, 0);
    finishRun();
  end

endmodule